// File: doc/BRIEF.md
# Sub-field SRAM write address generator

This block produces the write address for an external frame memory that stores bit-plane-separated video data. Each valid input word carries the bits of one weight for a group of eight pixels. The block places all words of the same weight from a frame into one contiguous segment of the memory. Eight segments cover eight weights, which gives 256 gray levels per color.

The address is built from four cascaded wrap-around counters: weight (field), column group, line within a zone, and zone. The weight counter steps fastest. The address bits, however, are packed with the weight in the most significant position, so consecutive writes are spread across the eight segments. A vertical-sync input restarts the frame. A one-clock pulse marks the write of the last word of a complete frame.

Top module: `sfw_addr_gen`

## Requirements
- R1: `wrAddr` is the concatenation, from MSB to LSB, of weight (bits 17..15), zone (bits 14..10), line within zone (bits 9..7) and column group (bits 6..0). It shows the position of the word presented in the current cycle.
- R2: On every clock with `wrValid` high and `vsync` low, the weight counter advances by one. After 7 it wraps to 0.
- R3: The column-group counter advances only when the weight counter wraps. It counts 0 to 99 (63h) and then wraps to 0.
- R4: The line-within-zone counter advances only when the column-group counter wraps. It counts 0 to 7 and then wraps to 0.
- R5: The zone counter advances only when the line counter wraps. It counts 0 to 31 and then wraps to 0.
- R6: A clock with `wrValid` low and `vsync` low leaves `wrAddr` unchanged and `frameDone` low.
- R7: `frameDone` is high for exactly the one clock that follows the accepted word at weight 7, column 99, line 7, zone 31. In that cycle `wrAddr` is 0.
- R8: A clock with `vsync` high clears all counters, so `wrAddr` is 0 in the next cycle and `frameDone` is low. `vsync` takes priority over `wrValid`, and a word presented with `vsync` is not counted.
- R9: While `rstN` is low, `wrAddr` is 0 and `frameDone` is low.

Note: the counter limits and field widths listed above use the default parameter values. The column and zone limits are parameters, and each field width is derived from its limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| vsync | input | 1 | Frame restart; clears all counters |
| wrValid | input | 1 | A bit-plane word is present this cycle |
| wrAddr | output | 18 | SRAM write address for the present word |
| frameDone | output | 1 | One-clock pulse after the last word of a frame |

## Verification
A counter that is off by one, or a carry taken at the wrong level, shows at once as a wrong field in `wrAddr`. The reference model tracks the four positions separately, and the bench compares each field on every clock, so the first word after the fault shows the mismatch. An error in the wrap limit of the column or zone counter shows only when that counter reaches its terminal value. For that reason one instance runs past several column and line wraps, and a second instance with a small column and zone count runs through many complete frames. A missing or misplaced end-of-frame pulse, and a restart that does not clear the counters, show within one cycle of the event that should cause them.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic advField;
    logic advCol;
    logic advLine;
    logic advZone;
    logic frameEnd;
  } sfwStrobe_t;

  // terminal-value flags from datapath to control
  typedef struct packed {
    logic fieldLast;
    logic colLast;
    logic lineLast;
    logic zoneLast;
  } sfwTerm_t;
endpackage

// File: rtl/sfw_wrap_counter.sv
module sfw_wrap_counter #(
  parameter int LIMIT = 8,
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         adv,
  output logic [W-1:0] count,
  output logic         last
);
  assign last = (count == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rstN)      count <= '0;
    else if (clear) count <= '0;
    else if (adv)   count <= last ? '0 : count + W'(1);
  end

  // R3/R5: counter never leaves its range
  a_r3_count_range: assert property (@(posedge clk) disable iff (!rstN)
    32'(count) < LIMIT);
endmodule

// File: rtl/sfw_ctrl.sv
module sfw_ctrl
  import sfw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       vsync,
  input  logic       wrValid,
  input  sfwTerm_t   term,
  output sfwStrobe_t stb,
  output logic       frameDone
);
  always_comb begin
    stb.clear    = vsync;
    stb.advField = wrValid & ~vsync;
    stb.advCol   = stb.advField & term.fieldLast;
    stb.advLine  = stb.advCol & term.colLast;
    stb.advZone  = stb.advLine & term.lineLast;
    stb.frameEnd = stb.advZone & term.zoneLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) frameDone <= 1'b0;
    else       frameDone <= stb.frameEnd;
  end

  // R7: end-of-frame pulse lasts a single clock
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);
  // R6: no pulse follows an idle cycle
  a_r6_idle_no_done: assert property (@(posedge clk) disable iff (!rstN)
    (!wrValid && !vsync) |=> !frameDone);
endmodule

// File: rtl/sfw_datapath.sv
module sfw_datapath
  import sfw_pkg::*;
#(
  parameter int NUM_FIELDS = 8,
  parameter int NUM_COLS   = 100,
  parameter int NUM_LINES  = 8,
  parameter int NUM_ZONES  = 32,
  localparam int FW = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int CW = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int ZW = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1,
  localparam int AW = FW + ZW + LW + CW
) (
  input  logic          clk,
  input  logic          rstN,
  input  sfwStrobe_t    stb,
  output sfwTerm_t      term,
  output logic [AW-1:0] addr
);
  logic [FW-1:0] fieldCnt;
  logic [CW-1:0] colCnt;
  logic [LW-1:0] lineCnt;
  logic [ZW-1:0] zoneCnt;

  sfw_wrap_counter #(.LIMIT(NUM_FIELDS)) uField (
    .clk(clk), .rstN(rstN), .clear(stb.clear), .adv(stb.advField),
    .count(fieldCnt), .last(term.fieldLast));
  sfw_wrap_counter #(.LIMIT(NUM_COLS)) uCol (
    .clk(clk), .rstN(rstN), .clear(stb.clear), .adv(stb.advCol),
    .count(colCnt), .last(term.colLast));
  sfw_wrap_counter #(.LIMIT(NUM_LINES)) uLine (
    .clk(clk), .rstN(rstN), .clear(stb.clear), .adv(stb.advLine),
    .count(lineCnt), .last(term.lineLast));
  sfw_wrap_counter #(.LIMIT(NUM_ZONES)) uZone (
    .clk(clk), .rstN(rstN), .clear(stb.clear), .adv(stb.advZone),
    .count(zoneCnt), .last(term.zoneLast));

  // weight in the MSBs, so consecutive words land in different segments
  assign addr = {fieldCnt, zoneCnt, lineCnt, colCnt};

  // R2: weight wraps after its last value
  a_r2_field_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advField && term.fieldLast) |=> fieldCnt == '0);
  // R3: column holds while the weight counter is not wrapping
  a_r3_col_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clear && !(stb.advField && term.fieldLast)) |=> $stable(colCnt));
  // R4: line holds unless the column counter wraps
  a_r4_line_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clear && !stb.advLine) |=> $stable(lineCnt));
endmodule

// File: rtl/sfw_addr_gen.sv
module sfw_addr_gen
  import sfw_pkg::*;
#(
  parameter int NUM_COLS  = 100,
  parameter int NUM_ZONES = 32,
  localparam int NUM_FIELDS = 8,
  localparam int NUM_LINES  = 8,
  localparam int AW = $clog2(NUM_FIELDS) + ((NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1)
                    + $clog2(NUM_LINES) + ((NUM_COLS > 1) ? $clog2(NUM_COLS) : 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          vsync,
  input  logic          wrValid,
  output logic [AW-1:0] wrAddr,
  output logic          frameDone
);
  sfwStrobe_t stb;
  sfwTerm_t   term;

  sfw_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .vsync(vsync), .wrValid(wrValid),
    .term(term), .stb(stb), .frameDone(frameDone));

  sfw_datapath #(
    .NUM_FIELDS(NUM_FIELDS), .NUM_COLS(NUM_COLS),
    .NUM_LINES(NUM_LINES), .NUM_ZONES(NUM_ZONES)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .term(term), .addr(wrAddr));

  // R7: the frame pulse coincides with a fully wrapped address
  a_r7_done_addr_zero: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> wrAddr == '0);
  // R8: restart clears the address and suppresses the pulse
  a_r8_vsync_clear: assert property (@(posedge clk) disable iff (!rstN)
    vsync |=> (wrAddr == '0 && !frameDone));
  // R6: idle cycles hold the address
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!wrValid && !vsync) |=> $stable(wrAddr));
endmodule

// File: tb/tb_sfw_addr_gen.sv
module tb_sfw_addr_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vsync = 1'b0;
  logic wrValid = 1'b0;
  logic [17:0] wrAddr;
  logic frameDone;
  logic [9:0] smAddr;
  logic smDone;
  int nChecks = 0;
  int nFails = 0;
  int smFrames = 0;

  always #2 clk = ~clk;  // 250 MHz

  sfw_addr_gen dut (.clk(clk), .rstN(rstN), .vsync(vsync), .wrValid(wrValid),
                    .wrAddr(wrAddr), .frameDone(frameDone));
  // small geometry: 4 column groups, 4 zones -> 10-bit address
  sfw_addr_gen #(.NUM_COLS(4), .NUM_ZONES(4)) dutSmall (
    .clk(clk), .rstN(rstN), .vsync(vsync), .wrValid(wrValid),
    .wrAddr(smAddr), .frameDone(smDone));

  // behavioural reference model: positions of the next word
  int mF = 0, mC = 0, mL = 0, mZ = 0, mD = 0;
  int sF = 0, sC = 0, sL = 0, sZ = 0, sD = 0;

  task automatic step_model(inout int f, inout int c, inout int l, inout int z,
                            output int d, input int nc, input int nz);
    d = (f == 7 && c == nc - 1 && l == 7 && z == nz - 1) ? 1 : 0;
    f = f + 1;
    if (f == 8) begin
      f = 0; c = c + 1;
      if (c == nc) begin
        c = 0; l = l + 1;
        if (l == 8) begin
          l = 0; z = z + 1;
          if (z == nz) z = 0;
        end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rstN || vsync) begin
      mF = 0; mC = 0; mL = 0; mZ = 0; mD = 0;
      sF = 0; sC = 0; sL = 0; sZ = 0; sD = 0;
    end else if (wrValid) begin
      step_model(mF, mC, mL, mZ, mD, 100, 32);
      step_model(sF, sC, sL, sZ, sD, 4, 4);
    end else begin
      mD = 0; sD = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  logic prevV = 1'b0, prevS = 1'b0;
  logic [17:0] prevAddr = '0;

  task automatic compare_all();
    check("R1 packed address", int'(wrAddr), (mF << 15) | (mZ << 10) | (mL << 7) | mC);
    check("R2 weight field", int'(wrAddr[17:15]), mF);
    check("R3 column field", int'(wrAddr[6:0]), mC);
    check("R4 line field", int'(wrAddr[9:7]), mL);
    check("R5 zone field", int'(wrAddr[14:10]), mZ);
    check("R7 frameDone", int'(frameDone), mD);
    check("R1 small address", int'(smAddr), (sF << 7) | (sZ << 5) | (sL << 2) | sC);
    check("R7 small frameDone", int'(smDone), sD);
    if (smDone) smFrames++;
    if (!prevV && !prevS) begin
      check("R6 idle holds address", int'(wrAddr), int'(prevAddr));
      check("R6 idle no pulse", int'(frameDone), 0);
    end
    if (prevS) begin
      check("R8 vsync clears address", int'(wrAddr), 0);
      check("R8 vsync clears small address", int'(smAddr), 0);
    end
  endtask

  // one cycle: check at the falling edge, then drive the next inputs
  task automatic cycle(input logic v, input logic s);
    @(negedge clk);
    compare_all();
    prevV = wrValid; prevS = vsync; prevAddr = wrAddr;
    prevV = v; prevS = s;
    wrValid = v; vsync = s;
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check("R9 reset address", int'(wrAddr), 0);
      check("R9 reset frameDone", int'(frameDone), 0);
    end
    rstN = 1'b1;
    prevV = 1'b0; prevS = 1'b0; prevAddr = '0;
    // sparse valid with occasional restarts
    for (int i = 0; i < 3000; i++)
      cycle(1'($urandom % 2), 1'($urandom % 400 == 0));
    cycle(1'b0, 1'b1);
    // dense run: many column and line wraps, many small frames
    for (int i = 0; i < 20000; i++)
      cycle(1'b1, 1'(i == 9000));
    // vsync together with valid: the word is not counted (R8)
    cycle(1'b1, 1'b0);
    cycle(1'b1, 1'b1);
    cycle(1'b1, 1'b0);
    cycle(1'b0, 1'b0);
    cycle(1'b0, 1'b0);
    check("R7 small frames completed", int'(smFrames > 10), 1);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule